// File: doc/BRIEF.md
# Bit-Stuffing NRZI Line Encoder

This block turns a serial packet bit stream into a single-ended line level for a USB-style link. For every packet it first sends a synchronisation byte of value 80H, least significant bit first. It then passes the payload bits through a bit-stuffing stage, which inserts a zero after every sixth consecutive one. The combined stream is coded as NRZI, so a zero flips the line and a one leaves it where it is. A line-drive enable flag is raised for as long as coded bits are on the line. After the packet the block drops the flag and parks the line at the idle (J) level, logic 1.

The source side is a one-bit valid/ready stream with start-of-packet and end-of-packet marks. A transfer takes place on a rising edge where both `src_valid` and `src_ready` are high. The block asks for no bits while it is idle or sending the sync byte. It also withholds ready in each cycle in which it emits a stuffed zero, so the source sees back-pressure and must hold its bit. Inside a packet the source is expected to keep `src_valid` high. A cycle without valid inserts no bit, and the line holds its level for that cycle. A stuffed bit carries no payload and exists only to give the receiver edges to lock onto.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: Out of reset and whenever no packet is in progress, `line_lvl` is 1, `line_drv` is 0 and `src_ready` is 0.
- R2: A bit offered with `src_valid` and `src_sop` while the block is idle starts a packet. The line then carries eight sync bits, seven 0s followed by a 1, and `src_ready` stays low until they are sent. Coded from the J level, this gives the levels 0,1,0,1,0,1,0,0.
- R3: The NRZI level restarts at J (1) for every packet. Each coded 0 inverts the line level and each coded 1 keeps it, with one coded bit per line cycle.
- R4: Once six 1s in a row have been coded, a 0 is inserted before the next bit. The final 1 of the sync byte counts towards that run, and any 0, stuffed or real, clears the run.
- R5: `src_ready` is low in exactly the cycles in which a stuffed 0 is emitted after the first payload bit, and the pending source bit is not consumed in those cycles.
- R6: If the end-of-packet bit completes a run of six 1s, a stuffed 0 is still emitted before the line goes idle.
- R7: After the final coded bit of a packet, that level stays on the line with `line_drv` high for one cycle. `line_drv` then falls and `line_lvl` returns to 1.
- R8: Payload bits are coded in the order they are accepted. A cycle inside a packet in which `src_valid` is low adds no bit, and the line level is held for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source offers a bit |
| src_ready | output | 1 | Block accepts the offered bit this cycle |
| src_bit | input | 1 | Payload bit value |
| src_sop | input | 1 | Offered bit is the first of a packet |
| src_eop | input | 1 | Offered bit is the last of a packet |
| line_lvl | output | 1 | Single-ended NRZI line level |
| line_drv | output | 1 | Line drive enable |

## Verification
Some properties are checked on every cycle. The ones-run counter never exceeds six, and a run of six is always followed by a cleared run. No bit is accepted while a stuff is pending. Every coded 0 flips the line and every coded 1 holds it, and the undriven line always sits at 1. Other behaviour only the bench scenarios can show. That covers the full sync pattern, the exact position and number of stuffed bits, and the tail stuff after end-of-packet. It also covers the one-cycle hold at packet end and the effect of a source gap. To show these, the bench compares every captured line sequence with one it computes from the payload. The payload sweep covers every 10-bit pattern and every pattern of one to three bits.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYNC = 2'd1,
    TX_BODY = 2'd2,
    TX_TAIL = 2'd3
  } tx_phase_e;

endpackage

// File: rtl/nrzi_run_counter.sv
module nrzi_run_counter #(
  parameter int RUN_LIMIT = 6,
  parameter int RUN_W     = $clog2(RUN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             coded_vld,
  input  logic             coded_bit,
  output logic [RUN_W-1:0] ones_run
);

  logic [RUN_W-1:0] run_q;

  // counts consecutive coded ones; any coded zero restarts the run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear) begin
      run_q <= '0;
    end else if (coded_vld) begin
      if (coded_bit) run_q <= run_q + RUN_W'(1);
      else           run_q <= '0;
    end
  end

  assign ones_run = run_q;

endmodule

// File: rtl/nrzi_line_coder.sv
module nrzi_line_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic park,
  input  logic coded_vld,
  input  logic coded_bit,
  output logic line_lvl,
  output logic line_drv
);

  logic lvl_q;
  logic drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      drv_q <= 1'b0;
    end else if (park) begin
      // J level, undriven; also the starting point of the next packet
      lvl_q <= 1'b1;
      drv_q <= 1'b0;
    end else if (coded_vld) begin
      lvl_q <= coded_bit ? lvl_q : ~lvl_q;
      drv_q <= 1'b1;
    end
  end

  assign line_lvl = lvl_q;
  assign line_drv = drv_q;

endmodule

// File: rtl/nrzi_tx_ctrl.sv
module nrzi_tx_ctrl
  import nrzi_tx_pkg::*;
#(
  parameter int RUN_LIMIT = 6,
  parameter int SYNC_LEN  = 8,
  parameter int RUN_W     = $clog2(RUN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic             src_bit,
  input  logic             src_sop,
  input  logic             src_eop,
  input  logic [RUN_W-1:0] ones_run,
  output logic             src_ready,
  output logic             coded_vld,
  output logic             coded_bit,
  output logic             park
);

  localparam int IDX_W = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam logic [IDX_W-1:0] SYNC_LAST = IDX_W'(SYNC_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL  = RUN_W'(RUN_LIMIT);
  localparam logic [RUN_W-1:0] RUN_NEAR  = RUN_W'(RUN_LIMIT - 1);

  tx_phase_e        phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stuff_due;

  assign stuff_due = (ones_run == RUN_FULL);

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    src_ready = 1'b0;
    coded_vld = 1'b0;
    coded_bit = 1'b0;
    park      = 1'b0;
    unique case (phase_q)
      TX_IDLE: begin
        park  = 1'b1;
        idx_d = '0;
        if (src_valid && src_sop) phase_d = TX_SYNC;
      end
      TX_SYNC: begin
        coded_vld = 1'b1;
        coded_bit = (idx_q == SYNC_LAST);
        if (idx_q == SYNC_LAST) phase_d = TX_BODY;
        else                    idx_d   = idx_q + IDX_W'(1);
      end
      TX_BODY: begin
        if (stuff_due) begin
          coded_vld = 1'b1;
        end else begin
          src_ready = 1'b1;
          if (src_valid) begin
            coded_vld = 1'b1;
            coded_bit = src_bit;
            if (src_eop)
              phase_d = (src_bit && ones_run == RUN_NEAR) ? TX_TAIL : TX_IDLE;
          end
        end
      end
      TX_TAIL: begin
        coded_vld = 1'b1;
        phase_d   = TX_IDLE;
      end
      default: phase_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx #(
  parameter int RUN_LIMIT = 6,
  parameter int SYNC_LEN  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_valid,
  output logic src_ready,
  input  logic src_bit,
  input  logic src_sop,
  input  logic src_eop,
  output logic line_lvl,
  output logic line_drv
);

  localparam int RUN_W = $clog2(RUN_LIMIT + 1);

  logic             coded_vld;
  logic             coded_bit;
  logic             park;
  logic [RUN_W-1:0] ones_run;

  nrzi_tx_ctrl #(
    .RUN_LIMIT(RUN_LIMIT),
    .SYNC_LEN (SYNC_LEN),
    .RUN_W    (RUN_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_valid(src_valid),
    .src_bit  (src_bit),
    .src_sop  (src_sop),
    .src_eop  (src_eop),
    .ones_run (ones_run),
    .src_ready(src_ready),
    .coded_vld(coded_vld),
    .coded_bit(coded_bit),
    .park     (park)
  );

  nrzi_run_counter #(
    .RUN_LIMIT(RUN_LIMIT),
    .RUN_W    (RUN_W)
  ) run_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (park),
    .coded_vld(coded_vld),
    .coded_bit(coded_bit),
    .ones_run (ones_run)
  );

  nrzi_line_coder coder_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .park     (park),
    .coded_vld(coded_vld),
    .coded_bit(coded_bit),
    .line_lvl (line_lvl),
    .line_drv (line_drv)
  );

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_run <= RUN_W'(RUN_LIMIT));

  assert_stuff_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_run == RUN_W'(RUN_LIMIT)) |=> (ones_run == '0));

  assert_stall_on_stuff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_run == RUN_W'(RUN_LIMIT)) |-> !src_ready);

  assert_zero_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coded_vld && !coded_bit) |=> (line_lvl != $past(line_lvl)));

  assert_one_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (coded_vld && coded_bit) |=> $stable(line_lvl));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_drv |-> line_lvl);

endmodule

// File: tb/nrzi_stuff_tx_tb_top.sv
module nrzi_stuff_tx_tb_top;

  localparam int RUN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_valid = 1'b0, src_bit = 1'b0, src_sop = 1'b0, src_eop = 1'b0;
  logic src_ready, line_lvl, line_drv;

  always #10 clk = ~clk;

  nrzi_stuff_tx dut_i (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_bit(src_bit), .src_sop(src_sop), .src_eop(src_eop),
    .line_lvl(line_lvl), .line_drv(line_drv)
  );

  int checks = 0;
  int errors = 0;
  logic cap [0:255];
  int cap_n = 0;
  logic pay [0:63];
  int pay_len = 0;
  logic exp_lv [0:255];
  int exp_n;

  always @(negedge clk) begin
    if (line_drv && cap_n < 256) begin
      cap[cap_n] = line_lvl;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sends pay[0..pay_len-1]; gap >= 0 withholds valid for one cycle before bit gap
  task automatic run_packet(input int gap);
    int run, st_exp, st_got, i, first_bad, bad;
    logic lv, b, tail, started, gap_done, r;
    run = 0; lv = 1'b1; exp_n = 0; st_exp = 0; tail = 1'b0;
    for (int k = 0; k < 8 + pay_len; k++) begin
      b = (k < 8) ? (k == 7) : pay[k-8];
      lv = b ? lv : ~lv; exp_lv[exp_n] = lv; exp_n++;
      run = b ? run + 1 : 0;
      if (gap >= 0 && k == 7 + gap) begin exp_lv[exp_n] = lv; exp_n++; end
      if (run == RUN) begin
        lv = ~lv; exp_lv[exp_n] = lv; exp_n++; run = 0;
        if (k >= 8 && k < 8 + pay_len - 1) st_exp++;
        if (k == 8 + pay_len - 1) tail = 1'b1;
      end
    end
    cap_n = 0; i = 0; st_got = 0; started = 1'b0; gap_done = 1'b0;
    while (i < pay_len) begin
      @(negedge clk);
      if (i == gap && !gap_done) begin
        src_valid = 1'b0; gap_done = 1'b1;
      end else begin
        src_valid = 1'b1; src_bit = pay[i];
        src_sop = (i == 0); src_eop = (i == pay_len - 1);
        r = src_ready;
        if (r) begin i++; started = 1'b1; end
        else if (started) st_got++;
      end
    end
    @(negedge clk);
    src_valid = 1'b0; src_sop = 1'b0; src_eop = 1'b0;
    repeat (4) @(negedge clk);
    check(cap_n == exp_n, "R4", "coded length", cap_n, exp_n);
    check(st_got == st_exp, "R5", "source stall cycles", st_got, st_exp);
    first_bad = -1; bad = 0;
    for (int k = 0; k < exp_n && k < cap_n; k++)
      if (cap[k] !== exp_lv[k] && first_bad < 0) first_bad = k;
    if (first_bad >= 0) bad = 1;
    check(bad == 0, "R3", "line level mismatch at index", first_bad, -1);
    if (tail)
      check(cap_n == exp_n && cap[cap_n-1] != cap[cap_n-2], "R6",
            "tail stuff toggle", int'(cap[cap_n-1]), int'(~cap[cap_n-2]));
    check(line_drv == 1'b0 && line_lvl == 1'b1, "R7", "idle drv,lvl",
          int'({line_drv, line_lvl}), 1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(line_lvl == 1'b1 && line_drv == 1'b0 && src_ready == 1'b0, "R1",
          "reset lvl,drv,ready", int'({line_lvl, line_drv, src_ready}), 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(line_lvl == 1'b1 && line_drv == 1'b0 && src_ready == 1'b0, "R1",
          "idle after reset", int'({line_lvl, line_drv, src_ready}), 4);

    // R2: sync pattern on a short packet
    pay_len = 2; pay[0] = 1'b0; pay[1] = 1'b0;
    run_packet(-1);
    begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[7-k] = cap[k];
      check(got == 8'b0101_0100, "R2", "sync levels", got, 8'b0101_0100);
    end

    // R4/R5: forty ones, stuffing throughout
    pay_len = 40; for (int k = 0; k < 40; k++) pay[k] = 1'b1;
    run_packet(-1);
    // R6: packet ends on a sixth one (sync 1 + five payload ones)
    pay_len = 5; for (int k = 0; k < 5; k++) pay[k] = 1'b1;
    run_packet(-1);
    // R6: zero then six ones at the end
    pay_len = 7; pay[0] = 1'b0; for (int k = 1; k < 7; k++) pay[k] = 1'b1;
    run_packet(-1);
    // R4: five ones after a zero, no stuff
    pay_len = 6; pay[0] = 1'b0; for (int k = 1; k < 6; k++) pay[k] = 1'b1;
    run_packet(-1);
    // R8: one-cycle source gap in an alternating packet
    pay_len = 10; for (int k = 0; k < 10; k++) pay[k] = k[0];
    run_packet(4);

    // R3/R4/R8: sweep all payloads of length 1..3 and all 10-bit payloads
    for (int len = 1; len <= 3; len++)
      for (int v = 0; v < (1 << len); v++) begin
        pay_len = len;
        for (int k = 0; k < len; k++) pay[k] = v[k];
        run_packet(-1);
      end
    for (int v = 0; v < 1024; v++) begin
      pay_len = 10;
      for (int k = 0; k < 10; k++) pay[k] = v[k];
      run_packet(-1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule